// File: doc/BRIEF.md
# Local Interrupt Controller Register Front End

This block is the register access layer of a per-core interrupt controller. A single request port presents a 12-bit byte offset, an access size and, for writes, a 32-bit data word. The block decodes the offset to one register and applies that register's own write rule. Depending on the register, the rule masks bits, forces bits to one, preserves read-only bits, ignores the write, or runs a two-step clear sequence. A response carrying the read data, or an error indication, is returned one cycle later.

Three 128-byte windows belong to the pending, in-service and trigger-mode bit arrays. These arrays are kept by neighbouring logic. For these windows the block only forwards a window select, a word index and a write strobe, and it returns the word that the neighbour supplies. Offsets outside the map and accesses that straddle an 8-byte word are refused. A refusal sets a sticky error output. Writing the end-of-interrupt register produces a one-cycle pulse for the priority logic.

Top module: `intc_reg_front`

## Requirements
- R1: Offset bits 2:0 do not take part in decoding. Registers sit on 16-byte slots: ID 0x20, version 0x30, task priority 0x80, end-of-interrupt 0xB0, logical destination 0xD0, destination format 0xE0, spurious vector 0xF0, error status 0x280, six vector entries 0x320–0x370, initial count 0x380, current count 0x390, divide 0x3E0. An 8-byte word with offset bit 3 set inside a register slot (for example 0x28) is unmapped.
- R2: req_size encodes the access length as 0=1, 1=2, 2=4 and 3=8 bytes. If offset[2:0] plus the length minus one exceeds 7, the access is refused: rsp_err=1, rdata=0, and no register changes.
- R3: Any unmapped offset is refused in the same way. This includes the command slots 0x300/0x310 and the slots 0x90/0xA0. A refusal sets access_err, which then stays high until reset.
- R4: The ID and task-priority registers keep only write bits 7:0. The logical-destination register keeps only write bits 31:24. All other bits read as zero.
- R5: A write to destination format stores bits 31:28 and reads back with bits 27:0 all ones. Its reset value is 0xFFFFFFFF.
- R6: Version reads the VERSION_VAL parameter. Current count reads cur_count_i. Writes to either register change nothing.
- R7: In each vector entry, bits 12 and 14 keep their previous value on a write, and the other bits take the written value. The reset value is 0x00010000.
- R8: Error status clears in two steps. The first write only arms an internal flag. The next write clears both the register and the flag. A read of error status disarms the flag.
- R9: Each err_set_i bit sets the matching error-status bit (bits 7:0) at the next edge. A bit that arrives in the same cycle as a clearing write survives the clear.
- R10: A spurious-vector write stores the full word and copies bit 8 to sw_enable. The reset value is 0x000000FF, with sw_enable=0.
- R11: A write to the end-of-interrupt slot raises eoi_pulse for exactly the following cycle and stores nothing. A read of that slot returns zero.
- R12: In the windows 0x100–0x17F, 0x180–0x1FF and 0x200–0x27F, arr_sel_o is 1, 2 and 3 respectively (0 elsewhere) and arr_idx_o is (offset − base)/8, both combinational. arr_we_o flags a write, and a read returns arr_rdata_i.
- R13: rsp_valid follows req_valid by one cycle, together with rsp_rdata and rsp_err. A write returns rdata 0.
- R14: Divide configuration keeps write bits 3, 1 and 0. Initial count stores all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset into the register space |
| req_size | input | 2 | Access length code |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Access refused |
| access_err | output | 1 | Sticky refusal flag |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| sw_enable | output | 1 | Software enable state |
| err_set_i | input | ERR_W | Error bits reported by other logic |
| cur_count_i | input | DATA_W | Live timer count |
| arr_sel_o | output | 2 | Bit-array window select |
| arr_idx_o | output | 4 | Word index in that window |
| arr_we_o | output | 1 | Write strobe for the bit arrays |
| arr_rdata_i | input | DATA_W | Word returned by the bit arrays |

## Verification
The error-status register can be cleared by software and set by hardware in the same cycle, and the result depends on which wins. The bench arms the clear sequence and then drives the clearing write while err_set_i pulses a fresh bit in that same cycle. It judges the outcome by reading the register back: the fresh bit must be present and every earlier bit gone. A clocked property also requires every reported bit to be visible one cycle after it arrives.

// File: rtl/intc_reg_pkg.sv
package intc_reg_pkg;

   typedef enum logic [3:0] {
      RG_NONE, RG_ID, RG_VER, RG_TPR, RG_EOI, RG_LDR, RG_DFR, RG_SVR,
      RG_ESR, RG_LVT, RG_INIT, RG_CUR, RG_DIV, RG_ARR
   } reg_kind_e;

   typedef enum logic [1:0] {
      ARR_NONE = 2'd0,
      ARR_ISR  = 2'd1,
      ARR_TMR  = 2'd2,
      ARR_IRR  = 2'd3
   } arr_kind_e;

   // slot numbers are offset[11:4]
   localparam logic [7:0] SLOT_ID   = 8'h02;
   localparam logic [7:0] SLOT_VER  = 8'h03;
   localparam logic [7:0] SLOT_TPR  = 8'h08;
   localparam logic [7:0] SLOT_EOI  = 8'h0B;
   localparam logic [7:0] SLOT_LDR  = 8'h0D;
   localparam logic [7:0] SLOT_DFR  = 8'h0E;
   localparam logic [7:0] SLOT_SVR  = 8'h0F;
   localparam logic [7:0] SLOT_ESR  = 8'h28;
   localparam logic [7:0] SLOT_LVT0 = 8'h32;
   localparam logic [7:0] SLOT_INIT = 8'h38;
   localparam logic [7:0] SLOT_CUR  = 8'h39;
   localparam logic [7:0] SLOT_DIV  = 8'h3E;

   // window numbers are offset[11:7]
   localparam logic [4:0] WIN_ISR = 5'h02;
   localparam logic [4:0] WIN_TMR = 5'h03;
   localparam logic [4:0] WIN_IRR = 5'h04;

   localparam logic [31:0] LVT_RO_MASK = 32'h0000_5000;
   localparam logic [31:0] LVT_RST     = 32'h0001_0000;
   localparam logic [3:0]  DIV_KEEP    = 4'hB;

   // true when the last byte of the access leaves the 8-byte word
   function automatic logic span_crosses(input logic [2:0] lo, input logic [1:0] sz);
      logic [3:0] last;
      last = {1'b0, lo} + ((4'd1 << sz) - 4'd1);
      return last[3];
   endfunction

endpackage

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
   import intc_reg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int LVT_N     = 6,
   parameter int LVT_IDX_W = 3
) (
   input  logic [ADDR_W-1:0]    offset,
   input  logic [1:0]           size,
   output reg_kind_e            kind,
   output logic [LVT_IDX_W-1:0] lvt_idx,
   output arr_kind_e            arr_kind,
   output logic [3:0]           arr_idx,
   output logic                 span_err
);

   logic       hi_ok;
   logic [7:0] slot;
   logic [7:0] lvt_off;

   if (ADDR_W > 12) begin : g_hi
      assign hi_ok = ~|offset[ADDR_W-1:12];
   end else begin : g_nohi
      assign hi_ok = 1'b1;
   end

   assign slot     = offset[11:4];
   assign lvt_off  = slot - SLOT_LVT0;
   assign span_err = span_crosses(offset[2:0], size);
   assign arr_idx  = offset[6:3];
   assign lvt_idx  = lvt_off[LVT_IDX_W-1:0];

   always_comb begin
      kind     = RG_NONE;
      arr_kind = ARR_NONE;
      if (hi_ok) begin
         unique case (offset[11:7])
            WIN_ISR: arr_kind = ARR_ISR;
            WIN_TMR: arr_kind = ARR_TMR;
            WIN_IRR: arr_kind = ARR_IRR;
            default: arr_kind = ARR_NONE;
         endcase
         if (arr_kind != ARR_NONE) begin
            kind = RG_ARR;
         end else if (!offset[3]) begin
            unique case (slot)
               SLOT_ID:   kind = RG_ID;
               SLOT_VER:  kind = RG_VER;
               SLOT_TPR:  kind = RG_TPR;
               SLOT_EOI:  kind = RG_EOI;
               SLOT_LDR:  kind = RG_LDR;
               SLOT_DFR:  kind = RG_DFR;
               SLOT_SVR:  kind = RG_SVR;
               SLOT_ESR:  kind = RG_ESR;
               SLOT_INIT: kind = RG_INIT;
               SLOT_CUR:  kind = RG_CUR;
               SLOT_DIV:  kind = RG_DIV;
               default: begin
                  if (slot >= SLOT_LVT0 && lvt_off < 8'(LVT_N))
                     kind = RG_LVT;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/intc_lvt_entry.sv
module intc_lvt_entry #(
   parameter int          DATA_W  = 32,
   parameter logic [31:0] RO_MASK = 32'h0000_5000,
   parameter logic [31:0] RST_VAL = 32'h0001_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   localparam logic [DATA_W-1:0] KEEP = RO_MASK[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL[DATA_W-1:0];
      else if (we) q <= (wdata & ~KEEP) | (q & KEEP);
   end

endmodule

// File: rtl/intc_err_status.sv
module intc_err_status #(
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [ERR_W-1:0] set_bits,
   output logic [ERR_W-1:0] q
);

   logic armed_q;
   logic do_clear;

   assign do_clear = wr && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= '0;
         armed_q <= 1'b0;
      end else begin
         q <= (do_clear ? '0 : q) | set_bits;
         if (wr)      armed_q <= ~armed_q;
         else if (rd) armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/intc_reg_front.sv
module intc_reg_front
   import intc_reg_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          DATA_W      = 32,
   parameter int          ERR_W       = 8,
   parameter int          LVT_N       = 6,
   parameter logic [31:0] VERSION_VAL = 32'h0006_0011,
   parameter bit          RSP_PIPE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              access_err,
   output logic              eoi_pulse,
   output logic              sw_enable,
   input  logic [ERR_W-1:0]  err_set_i,
   input  logic [DATA_W-1:0] cur_count_i,
   output logic [1:0]        arr_sel_o,
   output logic [3:0]        arr_idx_o,
   output logic              arr_we_o,
   input  logic [DATA_W-1:0] arr_rdata_i
);

   localparam int LVT_IDX_W = (LVT_N > 1) ? $clog2(LVT_N) : 1;

   if (DATA_W != 32) begin : g_bad_data
      initial $fatal(1, "intc_reg_front: DATA_W must be 32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      initial $fatal(1, "intc_reg_front: ADDR_W must be at least 12");
   end
   if (ERR_W < 1 || ERR_W > 32) begin : g_bad_err
      initial $fatal(1, "intc_reg_front: ERR_W out of range");
   end
   if (LVT_N < 1 || LVT_N > 6) begin : g_bad_lvt
      initial $fatal(1, "intc_reg_front: LVT_N must be 1..6");
   end

   reg_kind_e            kind;
   arr_kind_e            arr_kind;
   logic [LVT_IDX_W-1:0] lvt_idx;
   logic                 span_err;
   logic                 hit, bad, we, rd;

   intc_reg_decode #(
      .ADDR_W    (ADDR_W),
      .LVT_N     (LVT_N),
      .LVT_IDX_W (LVT_IDX_W)
   ) u_dec (
      .offset   (req_offset),
      .size     (req_size),
      .kind     (kind),
      .lvt_idx  (lvt_idx),
      .arr_kind (arr_kind),
      .arr_idx  (arr_idx_o),
      .span_err (span_err)
   );

   assign hit = req_valid && !span_err && (kind != RG_NONE);
   assign bad = req_valid && !hit;
   assign we  = hit && req_write;
   assign rd  = hit && !req_write;

   assign arr_sel_o = (req_valid && !span_err) ? arr_kind : ARR_NONE;
   assign arr_we_o  = we && (kind == RG_ARR);

   // ---------------- plain registers ----------------
   logic [7:0]        id_q, tpr_q, ldr_q;
   logic [3:0]        dfr_q, div_q;
   logic [DATA_W-1:0] svr_q, init_q;
   logic              sw_en_q, eoi_q, acc_err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q      <= '0;
         tpr_q     <= '0;
         ldr_q     <= '0;
         dfr_q     <= 4'hF;
         div_q     <= '0;
         svr_q     <= DATA_W'(32'h0000_00FF);
         init_q    <= '0;
         sw_en_q   <= 1'b0;
         eoi_q     <= 1'b0;
         acc_err_q <= 1'b0;
      end else begin
         eoi_q <= we && (kind == RG_EOI);
         if (bad) acc_err_q <= 1'b1;
         if (we) begin
            unique case (kind)
               RG_ID:   id_q   <= req_wdata[7:0];
               RG_TPR:  tpr_q  <= req_wdata[7:0];
               RG_LDR:  ldr_q  <= req_wdata[31:24];
               RG_DFR:  dfr_q  <= req_wdata[31:28];
               RG_DIV:  div_q  <= req_wdata[3:0] & DIV_KEEP;
               RG_INIT: init_q <= req_wdata;
               RG_SVR: begin
                  svr_q   <= req_wdata;
                  sw_en_q <= req_wdata[8];
               end
               default: ;
            endcase
         end
      end
   end

   assign eoi_pulse  = eoi_q;
   assign access_err = acc_err_q;
   assign sw_enable  = sw_en_q;

   // ---------------- vector-table entries ----------------
   logic [DATA_W-1:0] lvt_q [LVT_N];

   for (genvar g = 0; g < LVT_N; g++) begin : g_lvt
      logic ent_we;
      assign ent_we = we && (kind == RG_LVT) && (lvt_idx == LVT_IDX_W'(g));
      intc_lvt_entry #(
         .DATA_W  (DATA_W),
         .RO_MASK (LVT_RO_MASK),
         .RST_VAL (LVT_RST)
      ) u_ent (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (ent_we),
         .wdata (req_wdata),
         .q     (lvt_q[g])
      );
   end

   // ---------------- error status ----------------
   logic [ERR_W-1:0] esr_q;

   intc_err_status #(.ERR_W(ERR_W)) u_esr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (we && (kind == RG_ESR)),
      .rd       (rd && (kind == RG_ESR)),
      .set_bits (err_set_i),
      .q        (esr_q)
   );

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (rd) begin
         unique case (kind)
            RG_ID:   rd_val = {24'h0, id_q};
            RG_VER:  rd_val = VERSION_VAL;
            RG_TPR:  rd_val = {24'h0, tpr_q};
            RG_LDR:  rd_val = {ldr_q, 24'h0};
            RG_DFR:  rd_val = {dfr_q, 28'hFFF_FFFF};
            RG_SVR:  rd_val = svr_q;
            RG_ESR:  rd_val = DATA_W'(esr_q);
            RG_LVT:  rd_val = lvt_q[lvt_idx];
            RG_INIT: rd_val = init_q;
            RG_CUR:  rd_val = cur_count_i;
            RG_DIV:  rd_val = {28'h0, div_q};
            RG_ARR:  rd_val = arr_rdata_i;
            default: rd_val = '0;
         endcase
      end
   end

   // ---------------- response stage ----------------
   if (RSP_PIPE) begin : g_rsp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
         end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_val;
            rsp_err   <= bad;
         end
      end
   end else begin : g_rsp_comb
      assign rsp_valid = req_valid;
      assign rsp_rdata = rd_val;
      assign rsp_err   = bad;
   end

endmodule

// File: rtl/intc_reg_front_chk.sv
module intc_reg_front_chk #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int ERR_W    = 8,
   parameter bit RSP_PIPE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_offset,
   input logic [1:0]        req_size,
   input logic              wd8,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              access_err,
   input logic              eoi_pulse,
   input logic              sw_enable,
   input logic [ERR_W-1:0]  err_set_i,
   input logic [ERR_W-1:0]  esr_q
);

   localparam logic [ADDR_W-5:0] EOI_SLOT = (ADDR_W-4)'(8'h0B);
   localparam logic [ADDR_W-5:0] SVR_SLOT = (ADDR_W-4)'(8'h0F);

   logic fits, eoi_wr, svr_wr;
   assign fits   = ({1'b0, req_offset[2:0]} + ((4'd1 << req_size) - 4'd1)) <= 4'd7;
   assign eoi_wr = req_valid && req_write && fits && !req_offset[3]
                   && (req_offset[ADDR_W-1:4] == EOI_SLOT);
   assign svr_wr = req_valid && req_write && fits && !req_offset[3]
                   && (req_offset[ADDR_W-1:4] == SVR_SLOT);

   AST_EOI_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr |=> eoi_pulse); // R11
   AST_EOI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_pulse |-> $past(eoi_wr)); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      access_err |=> access_err); // R3
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0)); // R3
   AST_SWEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      svr_wr |=> (sw_enable == $past(wd8))); // R10
   AST_ESR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_set_i) |=> ((esr_q & $past(err_set_i)) == $past(err_set_i))); // R9

   if (RSP_PIPE) begin : g_lat
      AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid); // R13
      AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid); // R13
   end

endmodule

bind intc_reg_front intc_reg_front_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ERR_W    (ERR_W),
   .RSP_PIPE (RSP_PIPE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_offset (req_offset),
   .req_size   (req_size),
   .wd8        (req_wdata[8]),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .rsp_err    (rsp_err),
   .access_err (access_err),
   .eoi_pulse  (eoi_pulse),
   .sw_enable  (sw_enable),
   .err_set_i  (err_set_i),
   .esr_q      (esr_q)
);

// File: tb/intc_reg_front_test.sv
`timescale 1ns/1ps
module intc_reg_front_test;

   localparam logic [31:0] VER = 32'h0006_0011;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_offset = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err, access_err, eoi_pulse, sw_enable, arr_we_o;
   logic [31:0] rsp_rdata;
   logic [7:0]  err_set_i = '0;
   logic [31:0] cur_count_i = 32'h0000_1234;
   logic [1:0]  arr_sel_o;
   logic [3:0]  arr_idx_o;
   logic [31:0] arr_rdata_i = 32'hA5A5_0F0F;

   int n_run = 0, n_fail = 0;
   logic [31:0] r_data;
   logic        r_err, r_valid;

   intc_reg_front uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .access_err(access_err), .eoi_pulse(eoi_pulse), .sw_enable(sw_enable),
      .err_set_i(err_set_i), .cur_count_i(cur_count_i), .arr_sel_o(arr_sel_o),
      .arr_idx_o(arr_idx_o), .arr_we_o(arr_we_o), .arr_rdata_i(arr_rdata_i)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input logic w, input logic [11:0] off, input logic [1:0] sz,
                      input logic [31:0] d, input logic [7:0] es);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_offset = off; req_size = sz;
      req_wdata = d; err_set_i = es;
      @(posedge clk);
      #1;
      req_valid = 1'b0; err_set_i = '0;
      r_data = rsp_rdata; r_err = rsp_err; r_valid = rsp_valid;
   endtask

   task automatic wr(input logic [11:0] off, input logic [31:0] d);
      acc(1'b1, off, 2'd2, d, 8'h00);
   endtask

   task automatic rdv(input logic [11:0] off);
      acc(1'b0, off, 2'd2, 32'h0, 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_id, m_tpr, m_ldr, m_dfr, m_svr, m_init, m_div, m_esr;
   logic [31:0] m_lvt [6];
   logic        m_armed;

   task automatic model_reset();
      m_id = 0; m_tpr = 0; m_ldr = 0; m_dfr = 32'hFFFF_FFFF; m_svr = 32'hFF;
      m_init = 0; m_div = 0; m_esr = 0; m_armed = 1'b0;
      for (int i = 0; i < 6; i++) m_lvt[i] = 32'h0001_0000;
   endtask

   function automatic logic [11:0] pick_off(input int i);
      case (i)
         0: return 12'h020;  1: return 12'h030;  2: return 12'h080;
         3: return 12'h0D0;  4: return 12'h0E0;  5: return 12'h0F0;
         6: return 12'h280;  7: return 12'h380;  8: return 12'h390;
         9: return 12'h3E0;
         default: return 12'h320 + 12'((i - 10) * 16);
      endcase
   endfunction

   task automatic model_write(input logic [11:0] off, input logic [31:0] d);
      case (off)
         12'h020: m_id  = {24'h0, d[7:0]};
         12'h080: m_tpr = {24'h0, d[7:0]};
         12'h0D0: m_ldr = d & 32'hFF00_0000;
         12'h0E0: m_dfr = d | 32'h0FFF_FFFF;
         12'h0F0: m_svr = d;
         12'h380: m_init = d;
         12'h3E0: m_div = d & 32'hB;
         12'h280: begin
            if (m_armed) begin m_esr = 0; m_armed = 1'b0; end
            else m_armed = 1'b1;
         end
         12'h320, 12'h330, 12'h340, 12'h350, 12'h360, 12'h370: begin
            int k;
            k = (int'(off) - 'h320) / 16;
            m_lvt[k] = (d & ~32'h5000) | (m_lvt[k] & 32'h5000);
         end
         default: ;
      endcase
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] off);
      case (off)
         12'h020: return m_id;
         12'h030: return VER;
         12'h080: return m_tpr;
         12'h0D0: return m_ldr;
         12'h0E0: return m_dfr;
         12'h0F0: return m_svr;
         12'h280: return m_esr;
         12'h380: return m_init;
         12'h390: return cur_count_i;
         12'h3E0: return m_div;
         default: return m_lvt[(int'(off) - 'h320) / 16];
      endcase
   endfunction

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R3 reset access_err", {31'h0, access_err}, 32'h0);
      chk("R10 reset sw_enable", {31'h0, sw_enable}, 32'h0);
      chk("R11 reset eoi_pulse", {31'h0, eoi_pulse}, 32'h0);
      chk("R13 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);

      // reset values
      rdv(12'h0E0); chk("R5 reset dfr", r_data, 32'hFFFF_FFFF);
      chk("R13 rsp_valid after read", {31'h0, r_valid}, 32'h1);
      rdv(12'h340); chk("R7 reset lvt", r_data, 32'h0001_0000);
      rdv(12'h0F0); chk("R10 reset svr", r_data, 32'h0000_00FF);

      // masking rules
      wr(12'h020, 32'hABCD_EF12); chk("R13 write rdata zero", r_data, 32'h0);
      rdv(12'h020); chk("R4 id mask", r_data, 32'h0000_0012);
      acc(1'b0, 12'h023, 2'd0, 32'h0, 8'h0); chk("R1 low bits ignored", r_data, 32'h0000_0012);
      wr(12'h080, 32'h1234_56C7); rdv(12'h080); chk("R4 tpr mask", r_data, 32'h0000_00C7);
      wr(12'h0D0, 32'h9ABC_DEF0); rdv(12'h0D0); chk("R4 ldr mask", r_data, 32'h9A00_0000);
      wr(12'h0E0, 32'h5000_0000); rdv(12'h0E0); chk("R5 dfr force", r_data, 32'h5FFF_FFFF);
      wr(12'h030, 32'h0); rdv(12'h030); chk("R6 version ro", r_data, VER);
      wr(12'h390, 32'h0); cur_count_i = 32'h00BE_EF00;
      rdv(12'h390); chk("R6 current count", r_data, 32'h00BE_EF00);
      wr(12'h370, 32'hFFFF_FFFF); rdv(12'h370); chk("R7 lvt ro bits", r_data, 32'hFFFF_AFFF);
      rdv(12'h360); chk("R7 other entry untouched", r_data, 32'h0001_0000);
      wr(12'h3E0, 32'hFFFF_FFFF); rdv(12'h3E0); chk("R14 divide mask", r_data, 32'h0000_000B);
      wr(12'h380, 32'hDEAD_BEEF); rdv(12'h380); chk("R14 initial count", r_data, 32'hDEAD_BEEF);

      // spurious vector / sw enable
      wr(12'h0F0, 32'h0000_01FF); chk("R10 sw_enable set", {31'h0, sw_enable}, 32'h1);
      rdv(12'h0F0); chk("R10 svr readback", r_data, 32'h0000_01FF);
      wr(12'h0F0, 32'h0000_00EF); chk("R10 sw_enable clear", {31'h0, sw_enable}, 32'h0);

      // EOI pulse
      wr(12'h0B0, 32'h0); chk("R11 eoi pulse", {31'h0, eoi_pulse}, 32'h1);
      @(posedge clk); #1; chk("R11 eoi one cycle", {31'h0, eoi_pulse}, 32'h0);
      rdv(12'h0B0); chk("R11 eoi reads zero", r_data, 32'h0);

      // error status handshake
      acc(1'b0, 12'h020, 2'd2, 32'h0, 8'h05);
      rdv(12'h280); chk("R9 err bits latched", r_data, 32'h05);
      wr(12'h280, 32'h0); rdv(12'h280); chk("R8 first write arms only", r_data, 32'h05);
      wr(12'h280, 32'h0); rdv(12'h280); chk("R8 read disarmed", r_data, 32'h05);
      wr(12'h280, 32'h0); wr(12'h280, 32'h0); rdv(12'h280); chk("R8 second write clears", r_data, 32'h0);
      acc(1'b0, 12'h020, 2'd2, 32'h0, 8'h03);
      wr(12'h280, 32'h0);
      acc(1'b1, 12'h280, 2'd2, 32'h0, 8'h40);
      rdv(12'h280); chk("R9 set beats clear", r_data, 32'h40);

      // bit-array windows
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_offset = 12'h1A8; req_size = 2'd2;
      #1;
      chk("R12 window select", {30'h0, arr_sel_o}, 32'h2);
      chk("R12 word index", {28'h0, arr_idx_o}, 32'h5);
      chk("R12 write strobe", {31'h0, arr_we_o}, 32'h1);
      req_offset = 12'h278; #1;
      chk("R12 request window", {26'h0, arr_sel_o, arr_idx_o}, 32'h3F);
      req_offset = 12'h100; #1;
      chk("R12 in-service window", {26'h0, arr_sel_o, arr_idx_o}, 32'h10);
      @(posedge clk); #1; req_valid = 1'b0;
      rdv(12'h1F0); chk("R12 array read data", r_data, 32'hA5A5_0F0F);
      chk("R3 no error yet", {31'h0, access_err}, 32'h0);

      // refusals
      acc(1'b1, 12'h026, 2'd2, 32'hFF, 8'h0);
      chk("R2 span error flag", {31'h0, r_err}, 32'h1);
      rdv(12'h020); chk("R2 span write had no effect", r_data, 32'h0000_0012);
      acc(1'b0, 12'h021, 2'd3, 32'h0, 8'h0);
      chk("R2 span read data zero", r_data, 32'h0);
      rdv(12'h028); chk("R1 odd word unmapped", {31'h0, r_err}, 32'h1);
      rdv(12'h300); chk("R3 command slot refused", {r_data[30:0], r_err}, 32'h1);
      rdv(12'h090); chk("R3 unmapped err", {31'h0, r_err}, 32'h1);
      rdv(12'h020); chk("R3 sticky flag", {31'h0, access_err}, 32'h1);
      chk("R3 good access no err", {31'h0, r_err}, 32'h0);

      // random section after a fresh reset
      do_reset();
      #1; chk("R3 cleared by reset", {31'h0, access_err}, 32'h0);
      model_reset();
      cur_count_i = 32'h0000_7777;
      for (int n = 0; n < 400; n++) begin
         logic [11:0] off;
         logic [31:0] d;
         off = pick_off(int'($urandom % 16));
         d = $urandom;
         if ($urandom % 2 == 0) begin
            wr(off, d);
            model_write(off, d);
         end else begin
            logic [31:0] e;
            e = model_read(off);
            rdv(off);
            chk("R4-R8 random read", r_data, e);
            if (off == 12'h280) m_armed = 1'b0;
         end
      end
      chk("R10 sw_enable tracks svr", {31'h0, sw_enable}, {31'h0, m_svr[8]});

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule